// File: doc/BRIEF.md
# Dual-Interrupt GPIO Controller With Wake-up

This block manages a bank of general-purpose pins. Software sets each pin's direction and drive value through a small word-addressed register bus. Each input is brought into the clock domain through a two-stage synchronizer. A channel can then be filtered by a per-channel debouncer, which counts periods of a separate, slow debounce clock. The filtered value is what software reads back as the input data, and it is also what the event detectors watch.

While the system is active, four per-channel masks decide which conditions count as events: low level, high level, rising edge and falling edge. Each event sets its bit in two independent status registers. Each status register drives its own interrupt line through its own enable mask, so two different consumers can take interrupts from the same pins. Software clears status bits by writing ones to them.

While the system is idle, the active detectors are frozen. A separate toggle detector on the synchronized inputs records wake-up status for the channels that have wake-up enabled. It raises a single wake-up request for as long as the idle indication stays high.

Top module: `gpio_wake_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe_o` is 0 (all pins are inputs), and `irq_a_o`, `irq_b_o` and `wake_o` are low.
- R2: `pad_out_o` equals the drive-value register (word 1), and `pad_oe_o` equals the direction register (word 2). A 1 in the direction register means the pin is driven.
- R3: With debouncing off, the input-data register (word 0) shows a pad change on the third rising clock edge after the change.
- R4: A channel whose bit is set in the debounce-enable register (word 12) takes a new input value only after that value has been stable for N+1 debounce-clock periods. N is the 8-bit value in word 13. A shorter pulse leaves the input-data register unchanged.
- R5: The low-level mask (word 3) and the high-level mask (word 4) set a status bit for as long as the filtered input is at that level. Clearing the bit does not take effect while the level is still present.
- R6: The rising-edge mask (word 5) and the falling-edge mask (word 6) set a status bit on the matching transition of the filtered input. With both masks set, any toggle sets the bit.
- R7: Writing to status A (word 7) or status B (word 8) clears exactly the bits written as 1 and leaves all other bits unchanged.
- R8: Every active-mode event sets its bit in both status registers. `irq_a_o` is the OR of status A masked by enable A (word 9). `irq_b_o` is the OR of status B masked by enable B (word 10).
- R9: While `idle_i` is high, no status A or status B bit becomes set.
- R10: While `idle_i` is high, a toggle on a channel enabled in word 11 sets that channel's bit in the wake status register (word 14). `wake_o` is high only while `idle_i` is high and some wake status bit is set. Writing 1s to word 14 clears those bits, and toggles while `idle_i` is low set nothing.
- R11: Word 13 reads back only its low 8 bits, with the upper bits 0. Word 15 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| db_clk_i | input | 1 | Slow debounce clock, sampled as a tick |
| idle_i | input | 1 | High selects idle mode (wake-up path only) |
| pad_in_i | input | 32 | Pin input levels |
| pad_out_o | output | 32 | Pin drive values |
| pad_oe_o | output | 32 | Pin drive enables, 1 = output |
| addr_i | input | 4 | Register word address |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_a_o | output | 1 | Interrupt line A |
| irq_b_o | output | 1 | Interrupt line B |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach from the ports is the debounce rejection. A pulse has to overlap at most one debounce tick, and the tick's phase is hidden behind its own synchronizer. The bench therefore runs the debounce clock with a fixed period of eight interface cycles. It chooses pulse lengths and hold times that stay on the correct side of the N+1 tick window whatever the phase. Entering and leaving idle mode with pads already changed is driven directly, to show that no stale edge reaches the status registers on the way back.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_DIN     = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_DOUT    = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_OE      = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_LVL_LO  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_LVL_HI  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_RISE    = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_FALL    = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_STAT_A  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_STAT_B  = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_IEN_A   = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_IEN_B   = 4'd10;
  localparam logic [ADDR_W-1:0] ADR_WKEN    = 4'd11;
  localparam logic [ADDR_W-1:0] ADR_DB_EN   = 4'd12;
  localparam logic [ADDR_W-1:0] ADR_DB_VAL  = 4'd13;
  localparam logic [ADDR_W-1:0] ADR_WK_STAT = 4'd14;

  localparam int unsigned IRQ_LINES = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned NCH = 32,
  parameter int unsigned CW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NCH-1:0] en_i,
  input  logic [CW-1:0]  limit_i,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] q_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] cnt_q;
    logic          val_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        val_q <= 1'b0;
      end else if (!en_i[ch]) begin
        val_q <= d_i[ch];
        cnt_q <= '0;
      end else if (tick_i) begin
        if (d_i[ch] == val_q) begin
          cnt_q <= '0;
        end else if (cnt_q == limit_i) begin
          val_q <= d_i[ch];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign q_o[ch] = val_q;
  end

  // filtered channels move only on a debounce tick
  assert_hold_between_ticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (((q_o ^ $past(q_o)) & $past(en_i)) == '0));
endmodule

// File: rtl/gpio_event_det.sv
module gpio_event_det #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           active_i,
  input  logic [NCH-1:0] din_i,
  input  logic [NCH-1:0] lvl_lo_i,
  input  logic [NCH-1:0] lvl_hi_i,
  input  logic [NCH-1:0] rise_i,
  input  logic [NCH-1:0] fall_i,
  output logic [NCH-1:0] ev_o
);
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] lvl_ev, edge_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  always_comb begin
    lvl_ev  = (lvl_lo_i & ~din_i) | (lvl_hi_i & din_i);
    edge_ev = (rise_i & din_i & ~prev_q) | (fall_i & ~din_i & prev_q);
    ev_o    = active_i ? (lvl_ev | edge_ev) : '0;
  end
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int unsigned NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] ev_i,
  input  logic           clr_we_i,
  input  logic [NCH-1:0] clr_mask_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] stat_o,
  output logic           irq_o
);
  logic [NCH-1:0] stat_q, clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr) | ev_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);

  assert_event_sets_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((stat_o & $past(ev_i)) == $past(ev_i)));

  assert_w1c_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((stat_o & $past(clr_mask_i & ~ev_i)) == '0));
endmodule

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
  import gpio_wake_pkg::*;
#(
  parameter int unsigned NCH   = 32,
  parameter int unsigned DBW   = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              db_clk_i,
  input  logic              idle_i,
  input  logic [NCH-1:0]    pad_in_i,
  output logic [NCH-1:0]    pad_out_o,
  output logic [NCH-1:0]    pad_oe_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NCH-1:0]    wdata_i,
  output logic [NCH-1:0]    rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              wake_o
);
  localparam int unsigned PADW = NCH - DBW;

  logic [NCH-1:0] dout_q, oe_q, lvl_lo_q, lvl_hi_q, rise_q, fall_q;
  logic [NCH-1:0] ien_q [IRQ_LINES];
  logic [NCH-1:0] wken_q, db_en_q, wk_stat_q, wk_prev_q;
  logic [DBW-1:0] db_val_q;

  logic [NCH-1:0] pad_s, din, ev, wk_set, wk_clr;
  logic [NCH-1:0] stat [IRQ_LINES];
  logic [IRQ_LINES-1:0] irq;
  logic           db_s, db_prev_q, db_tick;

  // ---- register writes ----
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lvl_lo_q <= '0;
      lvl_hi_q <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      for (int l = 0; l < IRQ_LINES; l++) ien_q[l] <= '0;
      wken_q   <= '0;
      db_en_q  <= '0;
      db_val_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADR_DOUT:   dout_q   <= wdata_i;
        ADR_OE:     oe_q     <= wdata_i;
        ADR_LVL_LO: lvl_lo_q <= wdata_i;
        ADR_LVL_HI: lvl_hi_q <= wdata_i;
        ADR_RISE:   rise_q   <= wdata_i;
        ADR_FALL:   fall_q   <= wdata_i;
        ADR_IEN_A:  ien_q[0] <= wdata_i;
        ADR_IEN_B:  ien_q[1] <= wdata_i;
        ADR_WKEN:   wken_q   <= wdata_i;
        ADR_DB_EN:  db_en_q  <= wdata_i;
        ADR_DB_VAL: db_val_q <= wdata_i[DBW-1:0];
        default: ;
      endcase
    end
  end

  assign pad_out_o = dout_q;
  assign pad_oe_o  = oe_q;

  // ---- input path ----
  gpio_sync #(.W(NCH), .STAGES(SYNC_N)) u_pad_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(pad_s)
  );

  gpio_sync #(.W(1), .STAGES(SYNC_N)) u_dbclk_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(db_clk_i), .q_o(db_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) db_prev_q <= 1'b0;
    else         db_prev_q <= db_s;
  end
  assign db_tick = db_s & ~db_prev_q;

  gpio_debounce #(.NCH(NCH), .CW(DBW)) u_debounce (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (db_tick),
    .en_i   (db_en_q),
    .limit_i(db_val_q),
    .d_i    (pad_s),
    .q_o    (din)
  );

  // ---- active-mode events and interrupt lines ----
  gpio_event_det #(.NCH(NCH)) u_event (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(~idle_i),
    .din_i   (din),
    .lvl_lo_i(lvl_lo_q),
    .lvl_hi_i(lvl_hi_q),
    .rise_i  (rise_q),
    .fall_i  (fall_q),
    .ev_o    (ev)
  );

  for (genvar l = 0; l < IRQ_LINES; l++) begin : g_line
    gpio_irq_line #(.NCH(NCH)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev),
      .clr_we_i  (we_i && (addr_i == (ADR_STAT_A + ADDR_W'(l)))),
      .clr_mask_i(wdata_i),
      .en_i      (ien_q[l]),
      .stat_o    (stat[l]),
      .irq_o     (irq[l])
    );
  end

  assign irq_a_o = irq[0];
  assign irq_b_o = irq[1];

  // ---- idle-mode wake path: toggles on synchronized pins ----
  assign wk_set = idle_i ? (wken_q & (pad_s ^ wk_prev_q)) : '0;
  assign wk_clr = (we_i && addr_i == ADR_WK_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wk_prev_q <= '0;
      wk_stat_q <= '0;
    end else begin
      wk_prev_q <= pad_s;
      wk_stat_q <= (wk_stat_q & ~wk_clr) | wk_set;
    end
  end

  assign wake_o = idle_i & (|wk_stat_q);

  // ---- read mux ----
  always_comb begin
    case (addr_i)
      ADR_DIN:     rdata_o = din;
      ADR_DOUT:    rdata_o = dout_q;
      ADR_OE:      rdata_o = oe_q;
      ADR_LVL_LO:  rdata_o = lvl_lo_q;
      ADR_LVL_HI:  rdata_o = lvl_hi_q;
      ADR_RISE:    rdata_o = rise_q;
      ADR_FALL:    rdata_o = fall_q;
      ADR_STAT_A:  rdata_o = stat[0];
      ADR_STAT_B:  rdata_o = stat[1];
      ADR_IEN_A:   rdata_o = ien_q[0];
      ADR_IEN_B:   rdata_o = ien_q[1];
      ADR_WKEN:    rdata_o = wken_q;
      ADR_DB_EN:   rdata_o = db_en_q;
      ADR_DB_VAL:  rdata_o = {{PADW{1'b0}}, db_val_q};
      ADR_WK_STAT: rdata_o = wk_stat_q;
      default:     rdata_o = '0;
    endcase
  end

  assert_idle_freezes_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (((stat[0] & ~$past(stat[0])) | (stat[1] & ~$past(stat[1]))) == '0));

  assert_wake_only_in_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> ((wk_stat_q & ~$past(wk_stat_q)) == '0));

  assert_direction_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0));
endmodule

// File: tb/gpio_wake_ctrl_bench.sv
module gpio_wake_ctrl_bench;
  localparam int NCH = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            db_clk = 1'b0;
  logic            idle = 1'b0;
  logic [NCH-1:0]  pad_in = '0;
  logic [NCH-1:0]  pad_out, pad_oe, rdata;
  logic [3:0]      addr = '0;
  logic            we = 1'b0;
  logic [NCH-1:0]  wdata = '0;
  logic            irq_a, irq_b, wake;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;
  always #80 db_clk = ~db_clk;

  gpio_wake_ctrl u_gpio_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .db_clk_i(db_clk), .idle_i(idle),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b), .wake_o(wake)
  );

  function automatic logic [NCH-1:0] edge_ev(logic [NCH-1:0] o, logic [NCH-1:0] n,
                                             logic [NCH-1:0] r, logic [NCH-1:0] f);
    return (r & n & ~o) | (f & ~n & o);
  endfunction

  task automatic chk(string req, logic [NCH-1:0] got, logic [NCH-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [NCH-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [NCH-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NCH-1:0] v, r, f, ea, eb, exp, oldp;
    int unsigned seed = 32'h5eed_0042;
    v = $urandom(seed);

    wait_cyc(3);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      chk("R1 reg", v, '0);
    end
    chk("R1 oe", pad_oe, '0);
    chk("R1 lines", {29'd0, irq_a, irq_b, wake}, '0);

    // R2 outputs, random patterns
    for (int i = 0; i < 6; i++) begin
      r = $urandom(); f = $urandom();
      wr(4'd1, r); wr(4'd2, f);
      #1;
      chk("R2 out", pad_out, r);
      chk("R2 oe", pad_oe, f);
    end

    // R11 width and unused word
    wr(4'd13, 32'hFFFF_FF37);
    rd(4'd13, v); chk("R11 dbval", v, 32'h37);
    wr(4'd13, '0);
    wr(4'd15, 32'hDEAD_BEEF);
    rd(4'd15, v); chk("R11 unused", v, '0);

    // R3 exact input latency
    rd(4'd0, oldp);
    v = $urandom() | 32'h1;
    @(negedge clk); pad_in = v;
    wait_cyc(2); #1 chk("R3 before", rdata, oldp);
    wait_cyc(1); #1 chk("R3 at third edge", rdata, v);

    // R6 + R8 random edge events on both lines
    r = $urandom(); f = $urandom();
    ea = $urandom(); eb = $urandom();
    wr(4'd5, r); wr(4'd6, f); wr(4'd9, ea); wr(4'd10, eb);
    wait_cyc(6);
    wr(4'd7, '1); wr(4'd8, '1);
    exp = '0; oldp = pad_in;
    for (int i = 0; i < 10; i++) begin
      v = $urandom();
      @(negedge clk); pad_in = v;
      wait_cyc(6);
      exp |= edge_ev(oldp, v, r, f);
      oldp = v;
      rd(4'd7, v); chk("R6 stat_a", v, exp);
      rd(4'd8, v); chk("R8 stat_b", v, exp);
      chk("R8 irq_a", {31'd0, irq_a}, {31'd0, |(exp & ea)});
      chk("R8 irq_b", {31'd0, irq_b}, {31'd0, |(exp & eb)});
    end

    // R7 partial clear on A only
    wr(4'd7, 32'h0000_FFFF);
    rd(4'd7, v); chk("R7 cleared part", v, exp & 32'hFFFF_0000);
    rd(4'd8, v); chk("R7 B untouched", v, exp);

    // directed: both edges = toggle on channel 9
    wr(4'd5, 32'h200); wr(4'd6, 32'h200);
    wr(4'd7, '1); wr(4'd8, '1);
    @(negedge clk); pad_in[9] = ~pad_in[9];
    wait_cyc(6);
    rd(4'd7, v); chk("R6 toggle 1", v, 32'h200);
    wr(4'd7, '1);
    @(negedge clk); pad_in[9] = ~pad_in[9];
    wait_cyc(6);
    rd(4'd7, v); chk("R6 toggle 2", v, 32'h200);

    // R5 level detect
    wr(4'd5, '0); wr(4'd6, '0);
    wr(4'd7, '1); wr(4'd8, '1);
    @(negedge clk); pad_in[3] = 1'b1;
    wr(4'd4, 32'h8);
    wait_cyc(4);
    rd(4'd7, v); chk("R5 high sets", v, 32'h8);
    wr(4'd7, 32'h8);
    rd(4'd7, v); chk("R5 persists", v, 32'h8);
    wr(4'd4, '0);
    wr(4'd7, 32'h8);
    rd(4'd7, v); chk("R5 cleared", v, '0);
    @(negedge clk); pad_in[3] = 1'b0;
    wait_cyc(4);
    wr(4'd3, 32'h8);
    wait_cyc(2);
    rd(4'd8, v); chk("R5 low sets", v, 32'h8);
    wr(4'd3, '0); wr(4'd7, '1); wr(4'd8, '1);

    // R9 / R10 idle mode
    wr(4'd5, '1); wr(4'd6, '1);
    wr(4'd11, 32'h20);
    @(negedge clk); idle = 1'b1;
    @(negedge clk); pad_in[5] = ~pad_in[5]; pad_in[6] = ~pad_in[6];
    wait_cyc(6);
    chk("R10 wake high", {31'd0, wake}, 32'd1);
    rd(4'd14, v); chk("R10 wk stat", v, 32'h20);
    rd(4'd7, v); chk("R9 no status", v, '0);
    @(negedge clk); idle = 1'b0;
    #1 chk("R10 wake needs idle", {31'd0, wake}, '0);
    wait_cyc(4);
    rd(4'd7, v); chk("R9 no stale edge", v, '0);
    wr(4'd14, 32'h20);
    rd(4'd14, v); chk("R10 w1c", v, '0);
    @(negedge clk); pad_in[5] = ~pad_in[5];
    wait_cyc(6);
    rd(4'd14, v); chk("R10 active ignored", v, '0);
    rd(4'd7, v); chk("R6 active edge", v, 32'h20);
    wr(4'd5, '0); wr(4'd6, '0); wr(4'd7, '1); wr(4'd8, '1);

    // R4 debounce, N=2, tick every 8 cycles
    wr(4'd13, 32'd2);
    wr(4'd12, 32'h1);
    rd(4'd0, v); oldp = v;
    @(negedge clk); pad_in[0] = ~oldp[0];
    wait_cyc(6);
    @(negedge clk); pad_in[0] = oldp[0];
    wait_cyc(40);
    rd(4'd0, v); chk("R4 glitch rejected", {31'd0, v[0]}, {31'd0, oldp[0]});
    @(negedge clk); pad_in[0] = ~oldp[0];
    wait_cyc(10);
    rd(4'd0, v); chk("R4 not yet", {31'd0, v[0]}, {31'd0, oldp[0]});
    wait_cyc(40);
    rd(4'd0, v); chk("R4 accepted", {31'd0, v[0]}, {31'd0, ~oldp[0]});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule